// File: doc/BRIEF.md
# Edge-Selectable Pulse Event Counter

This block watches bit 7 of an 8-bit input port and counts its edges in an 8-bit event counter. New port values arrive with a strobe. Each one is merged into a held port register through a write mask. When that merge changes bit 7, the counter may advance. Whether it advances depends on an enable bit, a mode bit and an edge-polarity bit in a control register.

When an increment wraps the counter from 0xFF to 0x00, a sticky overflow flag is set. The interrupt request is raised while that flag and its interrupt-enable bit are both 1. Software reads and writes the control register and the counter through a small register port, and clears the flag by writing 1 to it.

The counting mode is held in a four-state machine that tracks the enable and mode bits:
- CNT_OFF_EVT: disabled, event mode.
- CNT_OFF_GATE: disabled, gated mode.
- CNT_RUN: enabled, event mode. This is the only state in which the counter advances.
- CNT_HOLD: enabled, gated-time mode. The count is held.

Every control-register write moves the machine straight to the state that its enable and mode bits encode. That is the single transition kind, from any state to any state. No other event changes the state.

Top module: `pulse_evt_counter`

## Requirements
- R1: After reset the counter, the control register, the overflow flag, the held port value and `irq` are all 0.
- R2: On `port_wr`, port bits 1:0 always take `port_in`. Bit 7 takes `port_in` only when control bit 3 (bit-7 direction, 1 = output) is 0. Bits 6:2 never change.
- R3: The counter advances only on a `port_wr` that changes held bit 7, while control bit 0 (enable) is 1 and control bit 1 (mode) is 0.
- R4: Control bit 2 selects the polarity. When it is 1, the counter counts when the new bit 7 is 1. When it is 0, the counter counts when the new bit 7 is 0.
- R5: An increment from 0xFF wraps the counter to 0x00 and sets the overflow flag (status bit 0).
- R6: A write to the counter (address 1) loads it. A write in the same cycle as an increment wins over the increment, and a write never sets the flag.
- R7: The flag is sticky. Writing 1 to status bit 0 clears it, writing 0 has no effect, and a wrap in the same cycle as a clear leaves the flag set.
- R8: `irq` is 1 exactly while the flag and control bit 4 (interrupt enable) are both 1.
- R9: With enable 1 and mode 1 (gated mode), the count is held whatever the port does.
- R10: The register map is: address 0 = control, address 1 = counter, address 2 = status (bit 0 = flag). Reads are combinational, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Strobe: new external port value present |
| port_in | input | 8 | External port value |
| port_q | output | 8 | Held port value after masking |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check on every cycle several properties. The count stays put when bit 7 does not change or when the machine is outside CNT_RUN. A qualifying increment from 0xFF yields 0x00 with the flag set. The flag survives any cycle without a clear. The held bit 7 stays frozen while its direction bit marks it as an output. Only the bench's scenarios can show three things: the polarity choice giving the right counts over a sequence of port values, the priority of a counter write over a simultaneous increment, and the register read-back of each state's encoding.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int EVT_BIT = 7;
    localparam logic [DATA_W-1:0] MASK_IN  = 8'h83;
    localparam logic [DATA_W-1:0] MASK_OUT = 8'h03;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    typedef enum logic [1:0] {
        CNT_OFF_EVT  = 2'b00,
        CNT_RUN      = 2'b01,
        CNT_OFF_GATE = 2'b10,
        CNT_HOLD     = 2'b11
    } cnt_state_e;
endpackage

// File: rtl/pec_port_latch.sv
module pec_port_latch
    import pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [DATA_W-1:0] port_in,
    input  logic              dir_out,
    output logic [DATA_W-1:0] port_q,
    output logic              chg_evt,
    output logic              new_evt
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] merged;

    always_comb begin
        mask    = dir_out ? MASK_OUT : MASK_IN;
        merged  = (port_in & mask) | (port_q & ~mask);
        chg_evt = port_wr && (merged[EVT_BIT] != port_q[EVT_BIT]);
        new_evt = merged[EVT_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       port_q <= '0;
        else if (port_wr) port_q <= merged;
    end

    assert_dir_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && dir_out) |=> $stable(port_q[EVT_BIT]));
    assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(port_q));
endmodule

// File: rtl/pec_counter.sv
module pec_counter
    import pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic              ctrl_mode,
    input  logic              edge_rise,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] cnt_wdata,
    input  logic              flag_clr,
    input  logic              chg_evt,
    input  logic              new_evt,
    output cnt_state_e        state_q,
    output logic [DATA_W-1:0] count_q,
    output logic              flag_q
);
    cnt_state_e        state_d;
    logic              inc;
    logic              wrap;
    logic [DATA_W-1:0] count_d;
    logic              flag_d;

    // state register process
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) state_d = cnt_state_e'({ctrl_mode, ctrl_en});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF_EVT;
        else        state_q <= state_d;
    end

    // output process: counter and flag next values
    always_comb begin
        inc = 1'b0;
        unique case (state_q)
            CNT_RUN:      inc = chg_evt && (new_evt == edge_rise);
            CNT_HOLD:     inc = 1'b0;
            CNT_OFF_EVT:  inc = 1'b0;
            CNT_OFF_GATE: inc = 1'b0;
        endcase
        wrap    = inc && (count_q == {DATA_W{1'b1}}) && !cnt_wr;
        count_d = cnt_wr ? cnt_wdata : (inc ? count_q + 1'b1 : count_q);
        flag_d  = wrap ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            count_q <= count_d;
            flag_q  <= flag_d;
        end
    end

    assert_hold_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_evt && !cnt_wr) |=> $stable(count_q));
    assert_hold_not_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CNT_RUN && !cnt_wr) |=> $stable(count_q));
    assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && chg_evt && new_evt == edge_rise && !cnt_wr
         && count_q == {DATA_W{1'b1}}) |=> (count_q == '0 && flag_q));
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/pulse_evt_counter.sv
module pulse_evt_counter
    import pec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_wr,
    input  logic [7:0]        port_in,
    output logic [7:0]        port_q,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    logic       edge_rise_q, dir_out_q, ien_q;
    logic       ctrl_wr, cnt_wr, flag_clr;
    logic       chg_evt, new_evt;
    cnt_state_e state_q;
    logic [DATA_W-1:0] count_q;
    logic       flag_q;

    assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    assign cnt_wr   = reg_wr && (reg_addr == A_CNT);
    assign flag_clr = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_rise_q <= 1'b0;
            dir_out_q   <= 1'b0;
            ien_q       <= 1'b0;
        end else if (ctrl_wr) begin
            edge_rise_q <= reg_wdata[2];
            dir_out_q   <= reg_wdata[3];
            ien_q       <= reg_wdata[4];
        end
    end

    pec_port_latch u_port (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_in(port_in),
        .dir_out(dir_out_q), .port_q(port_q), .chg_evt(chg_evt), .new_evt(new_evt)
    );

    pec_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .ctrl_en(reg_wdata[0]), .ctrl_mode(reg_wdata[1]), .edge_rise(edge_rise_q),
        .cnt_wr(cnt_wr), .cnt_wdata(reg_wdata), .flag_clr(flag_clr),
        .chg_evt(chg_evt), .new_evt(new_evt),
        .state_q(state_q), .count_q(count_q), .flag_q(flag_q)
    );

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {3'b000, ien_q, dir_out_q, edge_rise_q, state_q[1], state_q[0]};
            A_CNT:   reg_rdata = count_q;
            A_STAT:  reg_rdata = {7'b0, flag_q};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign irq = flag_q & ien_q;
endmodule

// File: tb/pulse_evt_counter_tb.sv
module pulse_evt_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_wr = 1'b0;
    logic [7:0] port_in = 8'h00;
    logic [7:0] port_q;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pulse_evt_counter u_dut (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_in(port_in),
        .port_q(port_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {port value pushed, expected held port, expected count}; rising edge, enabled
    localparam logic [23:0] VEC [8] = '{
        {8'h80, 8'h80, 8'd1}, {8'h80, 8'h80, 8'd1},
        {8'h00, 8'h00, 8'd1}, {8'h83, 8'h83, 8'd2},
        {8'h7F, 8'h03, 8'd2}, {8'hFF, 8'h83, 8'd3},
        {8'h01, 8'h01, 8'd3}, {8'h80, 8'h80, 8'd4}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic pw, input logic [7:0] pv,
                       input logic rw, input logic [1:0] ra, input logic [7:0] rd);
        @(negedge clk);
        port_wr = pw; port_in = pv; reg_wr = rw; reg_addr = ra; reg_wdata = rd;
        @(negedge clk);
        port_wr = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] v);
        cyc(1'b1, v, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b0, 8'h00, 1'b1, a, d);
    endtask

    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        #1500000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rreg(2'd0, r); check("R1 ctrl", r, 8'h00);
        rreg(2'd1, r); check("R1 count", r, 8'h00);
        rreg(2'd2, r); check("R1 flag", r, 8'h00);
        check("R1 port", port_q, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R2 R3 R4 table walk: enable + rising
        wreg(2'd0, 8'h05);
        for (int i = 0; i < 8; i++) begin
            push(VEC[i][23:16]);
            check("R2 port mask", port_q, VEC[i][15:8]);
            rreg(2'd1, r); check("R3 R4 count", r, VEC[i][7:0]);
        end

        // R4 falling edge
        wreg(2'd0, 8'h01);
        push(8'h00); rreg(2'd1, r); check("R4 falling", r, 8'd5);
        // R3 disabled
        wreg(2'd0, 8'h00);
        push(8'h80); push(8'h00); rreg(2'd1, r); check("R3 disabled", r, 8'd5);
        // R9 gated mode holds
        wreg(2'd0, 8'h03);
        rreg(2'd0, r); check("R10 ctrl gated", r, 8'h03);
        push(8'h80); rreg(2'd1, r); check("R9 hold", r, 8'd5);
        check("R9 port", port_q, 8'h80);
        // R2 bit 7 as output
        wreg(2'd0, 8'h0D);
        push(8'h03); check("R2 dir out", port_q, 8'h83);
        rreg(2'd1, r); check("R2 no count", r, 8'd5);
        push(8'h00); check("R2 dir out low", port_q, 8'h80);

        // R5 R6 R8 wrap
        wreg(2'd0, 8'h15);
        wreg(2'd1, 8'hFE);
        rreg(2'd2, r); check("R6 write no flag", r, 8'h00);
        push(8'h00); push(8'h80);
        rreg(2'd1, r); check("R5 at FF", r, 8'hFF);
        push(8'h00); push(8'h80);
        rreg(2'd1, r); check("R5 wrap", r, 8'h00);
        rreg(2'd2, r); check("R5 flag", r, 8'h01);
        check("R8 irq on", {7'b0, irq}, 8'h01);
        rreg(2'd0, r); check("R10 ctrl read", r, 8'h15);
        rreg(2'd3, r); check("R10 addr3", r, 8'h00);

        // R7 sticky and W1C
        wreg(2'd2, 8'h00);
        rreg(2'd2, r); check("R7 write0", r, 8'h01);
        wreg(2'd0, 8'h05);
        check("R8 irq masked", {7'b0, irq}, 8'h00);
        wreg(2'd2, 8'h01);
        rreg(2'd2, r); check("R7 clear", r, 8'h00);
        // R7 set wins over clear
        wreg(2'd1, 8'hFF);
        push(8'h00);
        cyc(1'b1, 8'h80, 1'b1, 2'd2, 8'h01);
        rreg(2'd2, r); check("R7 set wins", r, 8'h01);
        rreg(2'd1, r); check("R5 wrap2", r, 8'h00);
        // R6 write wins over increment
        push(8'h00);
        cyc(1'b1, 8'h80, 1'b1, 2'd1, 8'h40);
        rreg(2'd1, r); check("R6 write wins", r, 8'h40);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rreg(2'd1, r); check("R1 count after", r, 8'h00);
        rreg(2'd2, r); check("R1 flag after", r, 8'h00);
        rreg(2'd0, r); check("R1 ctrl after", r, 8'h00);
        check("R1 port after", port_q, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule